// File: doc/BRIEF.md
# Parameterized Integer ALU with Zero Flag

This block is a purely combinational arithmetic logic unit for an integer datapath. It takes two operand words and a 3-bit operation select, and returns one result word together with a flag that marks an all-zero result. The word width is a parameter. The default is 32 bits, and the block is also built at 4 bits for small datapaths and exhaustive checking.

Eight operations are provided:

- wrapping addition and subtraction
- three bitwise logic functions
- a signed less-than test
- logical shifts in both directions

The less-than test does not use a separate comparator. It is taken from the subtractor: the sign of the difference is XORed with the subtract overflow. The outcome sits in bit 0 of the result, and all other bits are zero. The zero flag lets a caller test equality by subtracting and then looking at one bit. The block holds no state, so its outputs follow its inputs with no clock.

Top module: `flex_alu`

## Requirements
- R1: With `op` = 3'b000 the result is `a + b` taken modulo 2^WIDTH. No carry is exported.
- R2: With `op` = 3'b001 the result is `a - b` taken modulo 2^WIDTH.
- R3: With `op` = 3'b010, 3'b011 and 3'b100 the result is the bitwise AND, OR and XOR of `a` and `b`. Each bit position is computed independently.
- R4: With `op` = 3'b101, bit 0 of the result is 1 exactly when `a` is less than `b` as two's-complement numbers. This also holds when `a - b` overflows. The value is formed as the difference's sign bit XOR the subtract overflow.
- R5: With `op` = 3'b101, result bits WIDTH-1 down to 1 are always 0.
- R6: With `op` = 3'b110 the result is `a` shifted left by `b` positions, with zeros filling in from the low end.
- R7: With `op` = 3'b111 the result is `a` shifted right by `b` positions, with zeros filling in from the high end.
- R8: For either shift, a shift amount `b` of WIDTH or more gives an all-zero result.
- R9: For every operation, `zero` is 1 if and only if the result word is all zeros.
- R10: The block meets R1 to R9 at WIDTH = 32 and at WIDTH = 4. Its outputs depend only on the current inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | WIDTH | First operand; the value that is shifted |
| b | input | WIDTH | Second operand; the shift amount for shifts |
| op | input | 3 | Operation select |
| result | output | WIDTH | Operation result |
| zero | output | 1 | High when the result is all zeros |

## Verification
The 32-bit build is run through a fixed table of corner vectors, followed by random operands and random operations. The table covers:

- an add that crosses the sign boundary and an add that wraps to zero, which tell a correct modular sum apart from one that saturates or leaks a carry
- subtractions that borrow and that overflow
- less-than pairs on both sides of the signed overflow boundary, which separate a true sign-XOR-overflow comparison from a plain sign test or an unsigned compare
- shifts by 0, by WIDTH-1 and by WIDTH or more, which expose wrong fill, a wrong shift direction and amounts that wrap

The 4-bit build is then checked over every combination of operands and select. This confirms that no width-dependent constant is wrong and that the zero flag follows every result.

// File: rtl/flex_alu_pkg.sv
package flex_alu_pkg;

   typedef enum logic [2:0] {
      OP_ADD = 3'b000,
      OP_SUB = 3'b001,
      OP_AND = 3'b010,
      OP_OR  = 3'b011,
      OP_XOR = 3'b100,
      OP_SLT = 3'b101,
      OP_SLL = 3'b110,
      OP_SRL = 3'b111
   } alu_op_e;

   typedef enum logic [1:0] {
      LG_AND = 2'd0,
      LG_OR  = 2'd1,
      LG_XOR = 2'd2
   } logic_fn_e;

endpackage

// File: rtl/flex_alu_addsub.sv
module flex_alu_addsub #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] x,
   input  logic [WIDTH-1:0] y,
   input  logic             sub,
   output logic [WIDTH-1:0] sum,
   output logic             ovf
);
   localparam int MSB = WIDTH - 1;

   logic [WIDTH-1:0] y_eff;

   assign y_eff = sub ? ~y : y;
   assign sum   = x + y_eff + {{(WIDTH-1){1'b0}}, sub};

   // Signed overflow. For subtract: the operand signs differ and the sign of
   // the difference differs from x. For add: the operand signs match and the
   // sign of the sum differs from them.
   always_comb begin
      if (sub)
         ovf = (x[MSB] != y[MSB]) && (sum[MSB] != x[MSB]);
      else
         ovf = (x[MSB] == y[MSB]) && (sum[MSB] != x[MSB]);
   end
endmodule

// File: rtl/flex_alu_logic.sv
module flex_alu_logic
   import flex_alu_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] x,
   input  logic [WIDTH-1:0] y,
   input  logic_fn_e        fn,
   output logic [WIDTH-1:0] z
);
   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      always_comb begin
         unique case (fn)
            LG_AND:  z[i] = x[i] & y[i];
            LG_OR:   z[i] = x[i] | y[i];
            default: z[i] = x[i] ^ y[i];
         endcase
      end
   end
endmodule

// File: rtl/flex_alu_shifter.sv
module flex_alu_shifter #(
   parameter int WIDTH = 32,
   parameter bit LEFT  = 1'b1
) (
   input  logic [WIDTH-1:0] x,
   input  logic [WIDTH-1:0] amt,
   output logic [WIDTH-1:0] z
);
   localparam int STAGES = $clog2(WIDTH);
   localparam logic [WIDTH-1:0] LIMIT = WIDTH'(WIDTH);

   logic [WIDTH-1:0] stage [0:STAGES];
   logic             too_far;

   assign stage[0] = x;
   assign too_far  = (amt >= LIMIT);

   for (genvar k = 0; k < STAGES; k++) begin : g_stage
      localparam int STEP = 1 << k;
      if (LEFT) begin : g_left
         assign stage[k+1] = amt[k] ? (stage[k] << STEP) : stage[k];
      end else begin : g_right
         assign stage[k+1] = amt[k] ? (stage[k] >> STEP) : stage[k];
      end
   end

   assign z = too_far ? '0 : stage[STAGES];
endmodule

// File: rtl/flex_alu.sv
module flex_alu
   import flex_alu_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic [2:0]       op,
   output logic [WIDTH-1:0] result,
   output logic             zero
);
   localparam int MSB = WIDTH - 1;

   if (WIDTH < 2) begin : g_width_check
      $error("flex_alu: WIDTH must be at least 2");
   end

   alu_op_e          opc;
   logic_fn_e        lfn;
   logic [WIDTH-1:0] arith;
   logic             arith_ovf;
   logic             is_sub;
   logic [WIDTH-1:0] bitwise;
   logic [WIDTH-1:0] shl;
   logic [WIDTH-1:0] shr;
   logic             less;

   assign opc = alu_op_e'(op);

   // Compare shares the subtractor with the subtract operation.
   assign is_sub = (opc == OP_SUB) || (opc == OP_SLT);

   always_comb begin
      unique case (opc)
         OP_AND:  lfn = LG_AND;
         OP_OR:   lfn = LG_OR;
         default: lfn = LG_XOR;
      endcase
   end

   flex_alu_addsub #(.WIDTH(WIDTH)) u_addsub (
      .x   (a),
      .y   (b),
      .sub (is_sub),
      .sum (arith),
      .ovf (arith_ovf)
   );

   flex_alu_logic #(.WIDTH(WIDTH)) u_logic (
      .x  (a),
      .y  (b),
      .fn (lfn),
      .z  (bitwise)
   );

   flex_alu_shifter #(.WIDTH(WIDTH), .LEFT(1'b1)) u_shl (
      .x   (a),
      .amt (b),
      .z   (shl)
   );

   flex_alu_shifter #(.WIDTH(WIDTH), .LEFT(1'b0)) u_shr (
      .x   (a),
      .amt (b),
      .z   (shr)
   );

   // Signed less-than: sign of the difference, flipped when it overflowed.
   assign less = arith[MSB] ^ arith_ovf;

   always_comb begin
      unique case (opc)
         OP_ADD, OP_SUB:         result = arith;
         OP_AND, OP_OR, OP_XOR:  result = bitwise;
         OP_SLT:                 result = {{(WIDTH-1){1'b0}}, less};
         OP_SLL:                 result = shl;
         default:                result = shr;
      endcase
   end

   assign zero = ~|result;
endmodule

// File: rtl/flex_alu_chk.sv
module flex_alu_chk #(
   parameter int WIDTH = 32
) (
   input logic [WIDTH-1:0] a,
   input logic [WIDTH-1:0] b,
   input logic [2:0]       op,
   input logic [WIDTH-1:0] result,
   input logic             zero
);
   localparam logic [WIDTH-1:0] LIMIT = WIDTH'(WIDTH);

   always_comb begin
      // R9
      zero_flag_chk: assert (zero == (result == '0));
      if (op == 3'b000) begin
         // R1
         add_wrap_chk: assert (WIDTH'(result - b) == a);
      end
      if (op == 3'b001) begin
         // R2
         sub_wrap_chk: assert (WIDTH'(result + b) == a);
      end
      if (op == 3'b101) begin
         // R5
         slt_zext_chk: assert (result[WIDTH-1:1] == '0);
         // R4
         slt_value_chk: assert (result[0] == ($signed(a) < $signed(b)));
      end
      if ((op == 3'b110 || op == 3'b111) && b >= LIMIT) begin
         // R8
         shift_range_chk: assert (result == '0);
      end
      if (op == 3'b010) begin
         // R3
         and_bits_chk: assert ((result & ~a) == '0 && (result & ~b) == '0);
      end
   end
endmodule

bind flex_alu flex_alu_chk #(.WIDTH(WIDTH)) u_chk (
   .a      (a),
   .b      (b),
   .op     (op),
   .result (result),
   .zero   (zero)
);

// File: tb/flex_alu_tb.sv
module flex_alu_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 15;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic [31:0] a32, b32, r32;
   logic [2:0]  op32;
   logic        z32;
   logic [3:0]  a4, b4, r4;
   logic [2:0]  op4;
   logic        z4;

   int checks = 0;
   int fails  = 0;

   flex_alu #(.WIDTH(32)) u_dut (
      .a(a32), .b(b32), .op(op32), .result(r32), .zero(z32));

   flex_alu #(.WIDTH(4)) u_dut4 (
      .a(a4), .b(b4), .op(op4), .result(r4), .zero(z4));

   // Each entry: {op, a, b, expected result}
   localparam logic [98:0] VEC [NVEC] = '{
      {3'b000, 32'h7FFF_FFFF, 32'h0000_0001, 32'h8000_0000},
      {3'b000, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000},
      {3'b001, 32'h0000_0005, 32'h0000_0007, 32'hFFFF_FFFE},
      {3'b001, 32'h8000_0000, 32'h0000_0001, 32'h7FFF_FFFF},
      {3'b010, 32'hF0F0_F0F0, 32'hFF00_FF00, 32'hF000_F000},
      {3'b011, 32'h0F0F_0000, 32'h0000_F0F0, 32'h0F0F_F0F0},
      {3'b100, 32'hAAAA_AAAA, 32'hFFFF_FFFF, 32'h5555_5555},
      {3'b101, 32'h8000_0000, 32'h7FFF_FFFF, 32'h0000_0001},
      {3'b101, 32'h7FFF_FFFF, 32'h8000_0000, 32'h0000_0000},
      {3'b101, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0001},
      {3'b110, 32'h0000_0001, 32'h0000_001F, 32'h8000_0000},
      {3'b111, 32'h8000_0000, 32'h0000_001F, 32'h0000_0001},
      {3'b110, 32'h1234_5678, 32'h0000_0020, 32'h0000_0000},
      {3'b111, 32'hFFFF_FFFF, 32'h0000_0021, 32'h0000_0000},
      {3'b110, 32'h0000_0003, 32'h0000_0000, 32'h0000_0003}
   };

   function automatic string req_of(input logic [2:0] op, input logic big);
      case (op)
         3'b000: return "R1";
         3'b001: return "R2";
         3'b010, 3'b011, 3'b100: return "R3";
         3'b101: return "R4";
         3'b110: return big ? "R8" : "R6";
         default: return big ? "R8" : "R7";
      endcase
   endfunction

   function automatic logic [31:0] ref32(input logic [2:0] op,
                                         input logic [31:0] a, input logic [31:0] b);
      case (op)
         3'b000: return a + b;
         3'b001: return a - b;
         3'b010: return a & b;
         3'b011: return a | b;
         3'b100: return a ^ b;
         3'b101: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
         3'b110: return (b >= 32) ? 32'd0 : (a << b[4:0]);
         default: return (b >= 32) ? 32'd0 : (a >> b[4:0]);
      endcase
   endfunction

   function automatic logic [3:0] ref4(input logic [2:0] op,
                                       input logic [3:0] a, input logic [3:0] b);
      int sa, sb;
      sa = a[3] ? int'(a) - 16 : int'(a);
      sb = b[3] ? int'(b) - 16 : int'(b);
      case (op)
         3'b000: return 4'(int'(a) + int'(b));
         3'b001: return 4'(int'(a) - int'(b));
         3'b010: return a & b;
         3'b011: return a | b;
         3'b100: return a ^ b;
         3'b101: return (sa < sb) ? 4'd1 : 4'd0;
         3'b110: return (b >= 4) ? 4'd0 : 4'((int'(a) << b) & 15);
         default: return (b >= 4) ? 4'd0 : 4'(int'(a) >> b);
      endcase
   endfunction

   task automatic check32(input string req, input logic [31:0] exp);
      checks++;
      if (r32 !== exp) begin
         fails++;
         $display("FAIL %s: op=%b a=%h b=%h result got %h expected %h",
                  req, op32, a32, b32, r32, exp);
      end
      checks++;
      if (z32 !== (exp == 32'd0)) begin
         fails++;
         $display("FAIL R9: op=%b a=%h b=%h zero got %b expected %b",
                  op32, a32, b32, z32, (exp == 32'd0));
      end
   endtask

   task automatic apply32(input logic [2:0] op, input logic [31:0] a,
                          input logic [31:0] b, input logic [31:0] exp);
      @(negedge clk);
      op32 = op; a32 = a; b32 = b;
      #1;
      check32(req_of(op, b >= 32), exp);
      if (op == 3'b101) begin
         checks++;
         if (r32[31:1] !== 31'd0) begin
            fails++;
            $display("FAIL R5: upper bits got %h expected 0", r32[31:1]);
         end
      end
   endtask

   initial begin
      op32 = 3'b000; a32 = '0; b32 = '0;
      op4  = 3'b000; a4  = '0; b4  = '0;
      repeat (3) @(posedge clk);
      rst = 1'b0;

      // Idle state, all inputs zero (R10, R9)
      @(negedge clk);
      #1;
      check32("R10", 32'd0);

      // R10: outputs follow the inputs with no clock edge in between
      a32 = 32'd9; b32 = 32'd4; op32 = 3'b001;
      #1;
      check32("R10", 32'd5);

      // Corner vector table
      for (int i = 0; i < NVEC; i++) begin
         apply32(VEC[i][98:96], VEC[i][95:64], VEC[i][63:32], VEC[i][31:0]);
      end

      // R9: subtract of equal operands gives zero
      apply32(3'b001, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 32'd0);
      // R5: a false compare leaves the whole word zero
      apply32(3'b101, 32'd5, 32'd5, 32'd0);

      // Random operands and operations at width 32
      for (int i = 0; i < 400; i++) begin
         logic [2:0]  op;
         logic [31:0] a, b;
         op = 3'($urandom_range(0, 7));
         a  = $urandom;
         b  = (op[2:1] == 2'b11 && i % 2 == 0) ? 32'($urandom_range(0, 40)) : $urandom;
         apply32(op, a, b, ref32(op, a, b));
      end

      // Exhaustive check at width 4 (R10)
      for (int op = 0; op < 8; op++) begin
         for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
               logic [3:0] exp;
               @(negedge clk);
               op4 = 3'(op); a4 = 4'(a); b4 = 4'(b);
               exp = ref4(3'(op), 4'(a), 4'(b));
               #1;
               checks++;
               if (r4 !== exp || z4 !== (exp == 4'd0)) begin
                  fails++;
                  $display("FAIL R10 (%s): op=%0d a=%h b=%h result/zero got %h/%b expected %h/%b",
                           req_of(3'(op), b >= 4), op, a, b, r4, z4, exp, (exp == 4'd0));
               end
            end
         end
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule